// File: doc/BRIEF.md
# Operand Address Resolver

This unit turns the addressing mode of an 8-bit processor instruction into the 16-bit address that the instruction works on. For a branch, that address is the branch target. A request carries a mode code, the one or two operand bytes that follow the opcode, the two index registers and the address of the opcode. Modes that need no memory produce their result straight away. The three pointer modes read two bytes through a byte-wide memory read port. The low byte is read first and the high byte second. The two bytes are assembled little-endian.

All three streams use valid/ready handshakes. The request stream transfers when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high only while the unit is idle, so one request is in flight at a time. The memory request stream transfers on `rd_valid && rd_ready`. While `rd_valid` waits for `rd_ready`, it stays high and `rd_addr` stays constant. The memory answers each accepted read with one `rsp_valid` pulse, one or more cycles later. Response pulses that arrive outside a wait for data are ignored. The result stream holds `ea_valid` and `ea_addr` until `ea_ready` is seen high. The unit becomes idle in the cycle after that transfer.

Mode codes on `req_mode`: 0 immediate, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 relative, 8 indirect, 9 indexed indirect (zero page + X, then pointer), 10 indirect indexed (pointer, then + Y). Codes 11 to 15 are reserved.

Top module: `addr_resolver`

## Requirements
- R1: `req_ready` is high only when no request is in flight: never in the same cycle as `rd_valid` or `ea_valid`. It is high after reset, when `rd_valid` and `ea_valid` are low.
- R2: Once `ea_valid` rises, `ea_valid` and `ea_addr` hold unchanged until a cycle with `ea_ready` high. After that transfer, `ea_valid` is low and `req_ready` is high.
- R3: Immediate mode (code 0) returns `pc + 1`, wrapping in 16 bits, and issues no memory read.
- R4: Zero page (code 1) returns {$00, lo}. Zero page + X or + Y (codes 2, 3) returns {$00, (lo + index) mod 256}. The high byte of these results is always $00.
- R5: Absolute (code 4) returns {hi, lo}. Absolute + X or + Y (codes 5, 6) returns {hi, lo} + index, wrapping in 16 bits.
- R6: Relative (code 7) returns `pc + 2` plus `lo` read as a signed byte (-128 to +127), wrapping in 16 bits.
- R7: Indirect (code 8) reads the pointer low byte at {hi, lo} and the high byte at {hi, lo} + 1, carried over 16 bits. It returns the pointer: with $D2 at $4000 and $FF at $4001, the result is $FFD2.
- R8: Indexed indirect (code 9) reads the low byte at {$00, lo + X} and the high byte at {$00, lo + X + 1}, with both sums wrapping within page zero. It returns the pointer: with bytes 00 40 C0 40 F8 50 40 A0 at $0010 and X = 4, the result is $50F8.
- R9: Indirect indexed (code 10) reads the low byte at {$00, lo} and the high byte at {$00, lo + 1}, with the second address wrapping within page zero. It returns the pointer + Y, wrapping in 16 bits: with the same table and Y = $20, the result is $4020.
- R10: A pointer mode makes exactly two accepted reads, the low-byte address first, and issues the second only after the first response. While `rd_valid` waits for `rd_ready`, `rd_addr` is stable.
- R11: Reserved codes 11 to 15 behave as absolute mode: they return {hi, lo} with no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted on this edge |
| req_mode | input | 4 | Addressing mode code |
| req_lo | input | 8 | First operand byte |
| req_hi | input | 8 | Second operand byte (absolute and indirect forms) |
| req_x | input | 8 | X index register |
| req_y | input | 8 | Y index register |
| req_pc | input | 16 | Address of the opcode byte |
| rd_valid | output | 1 | Memory read request offered |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 16 | Address of the byte to read |
| rsp_valid | input | 1 | Read data present (one pulse per read) |
| rsp_data | input | 8 | Read data |
| ea_valid | output | 1 | Result offered |
| ea_ready | input | 1 | Consumer takes the result |
| ea_addr | output | 16 | Effective address or branch target |

## Verification
Some properties are checked on every cycle, whatever the mode. These are the exclusion between idle and busy (R1) and the holding of the result under back-pressure (R2). The holding of the read address under back-pressure and the count of two reads per pointer request (R10) are checked the same way. So are the absence of reads for immediate mode (R3) and the page-zero confinement of the zero-page results and pointer reads (R4, R8). The arithmetic of each mode can only be shown by the bench's scenarios. This covers the 8-bit and 16-bit wrap points, the sign of the branch offset, the little-endian assembly and the order of X before and Y after the fetch (R5 to R9, R11). The bench compares the results against values it computes itself, under random memory latency and random back-pressure.

// File: rtl/addr_resolver_pkg.sv
package addr_resolver_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM    = 4'd0,
    AM_ZP     = 4'd1,
    AM_ZPX    = 4'd2,
    AM_ZPY    = 4'd3,
    AM_ABS    = 4'd4,
    AM_ABSX   = 4'd5,
    AM_ABSY   = 4'd6,
    AM_REL    = 4'd7,
    AM_IND    = 4'd8,
    AM_XIND   = 4'd9,
    AM_INDY   = 4'd10
  } am_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LO,
    ST_WAIT_LO,
    ST_REQ_HI,
    ST_WAIT_HI,
    ST_OUT
  } seq_st_e;

  function automatic logic is_ptr_mode(input logic [MODE_W-1:0] m);
    return (m == AM_IND) || (m == AM_XIND) || (m == AM_INDY);
  endfunction

  function automatic logic is_zp_mode(input logic [MODE_W-1:0] m);
    return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
  endfunction
endpackage

// File: rtl/am_decode.sv
module am_decode
  import addr_resolver_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     op_lo,
  input  logic [DW-1:0]     op_hi,
  input  logic [DW-1:0]     idx_x,
  input  logic [DW-1:0]     idx_y,
  input  logic [2*DW-1:0]   pc,
  output logic              use_ptr,
  output logic [2*DW-1:0]   direct_ea,
  output logic [2*DW-1:0]   ptr_lo_addr,
  output logic [2*DW-1:0]   ptr_hi_addr,
  output logic [2*DW-1:0]   post_add
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] PAGE0 = '0;
  localparam logic [AW-1:0] BR_LEN = AW'(2);

  logic [DW-1:0] zp_x, zp_y, zp_x_nxt, zp_nxt;
  logic [AW-1:0] abs_a, rel_off;

  always_comb begin
    zp_x     = op_lo + idx_x;
    zp_y     = op_lo + idx_y;
    zp_x_nxt = zp_x + DW'(1);
    zp_nxt   = op_lo + DW'(1);
    abs_a    = {op_hi, op_lo};
    rel_off  = {{DW{op_lo[DW-1]}}, op_lo};
  end

  always_comb begin
    use_ptr     = is_ptr_mode(mode);
    direct_ea   = abs_a;
    ptr_lo_addr = abs_a;
    ptr_hi_addr = abs_a + AW'(1);
    post_add    = '0;
    case (mode)
      AM_IMM:  direct_ea = pc + AW'(1);
      AM_ZP:   direct_ea = {PAGE0, op_lo};
      AM_ZPX:  direct_ea = {PAGE0, zp_x};
      AM_ZPY:  direct_ea = {PAGE0, zp_y};
      AM_ABSX: direct_ea = abs_a + {PAGE0, idx_x};
      AM_ABSY: direct_ea = abs_a + {PAGE0, idx_y};
      AM_REL:  direct_ea = pc + BR_LEN + rel_off;
      AM_XIND: begin
        ptr_lo_addr = {PAGE0, zp_x};
        ptr_hi_addr = {PAGE0, zp_x_nxt};
      end
      AM_INDY: begin
        ptr_lo_addr = {PAGE0, op_lo};
        ptr_hi_addr = {PAGE0, zp_nxt};
        post_add    = {PAGE0, idx_y};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ptr_sequencer.sv
module ptr_sequencer
  import addr_resolver_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            use_ptr,
  input  logic [2*DW-1:0] direct_ea,
  input  logic [2*DW-1:0] ptr_lo_addr,
  input  logic [2*DW-1:0] ptr_hi_addr,
  input  logic [2*DW-1:0] post_add,
  output logic            idle,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [2*DW-1:0] rd_addr,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  output logic            ea_valid,
  input  logic            ea_ready,
  output logic [2*DW-1:0] ea_addr
);
  localparam int AW = 2 * DW;

  seq_st_e       st_q;
  logic [AW-1:0] lo_addr_q, hi_addr_q, add_q, ea_q;
  logic [DW-1:0] lo_byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      lo_addr_q <= '0;
      hi_addr_q <= '0;
      add_q     <= '0;
      ea_q      <= '0;
      lo_byte_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          if (use_ptr) begin
            lo_addr_q <= ptr_lo_addr;
            hi_addr_q <= ptr_hi_addr;
            add_q     <= post_add;
            st_q      <= ST_REQ_LO;
          end else begin
            ea_q <= direct_ea;
            st_q <= ST_OUT;
          end
        end
        ST_REQ_LO:  if (rd_ready) st_q <= ST_WAIT_LO;
        ST_WAIT_LO: if (rsp_valid) begin
          lo_byte_q <= rsp_data;
          st_q      <= ST_REQ_HI;
        end
        ST_REQ_HI:  if (rd_ready) st_q <= ST_WAIT_HI;
        ST_WAIT_HI: if (rsp_valid) begin
          ea_q <= {rsp_data, lo_byte_q} + add_q;
          st_q <= ST_OUT;
        end
        ST_OUT:     if (ea_ready) st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle     = (st_q == ST_IDLE);
    rd_valid = (st_q == ST_REQ_LO) || (st_q == ST_REQ_HI);
    rd_addr  = (st_q == ST_REQ_HI) ? hi_addr_q : lo_addr_q;
    ea_valid = (st_q == ST_OUT);
    ea_addr  = ea_q;
  end
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
  import addr_resolver_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [3:0]      req_mode,
  input  logic [DW-1:0]   req_lo,
  input  logic [DW-1:0]   req_hi,
  input  logic [DW-1:0]   req_x,
  input  logic [DW-1:0]   req_y,
  input  logic [2*DW-1:0] req_pc,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [2*DW-1:0] rd_addr,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  output logic            ea_valid,
  input  logic            ea_ready,
  output logic [2*DW-1:0] ea_addr
);
  localparam int AW = 2 * DW;

  logic          use_ptr, idle;
  logic [AW-1:0] direct_ea, ptr_lo_addr, ptr_hi_addr, post_add;

  am_decode #(.DW(DW)) u_decode (
    .mode        (req_mode),
    .op_lo       (req_lo),
    .op_hi       (req_hi),
    .idx_x       (req_x),
    .idx_y       (req_y),
    .pc          (req_pc),
    .use_ptr     (use_ptr),
    .direct_ea   (direct_ea),
    .ptr_lo_addr (ptr_lo_addr),
    .ptr_hi_addr (ptr_hi_addr),
    .post_add    (post_add)
  );

  ptr_sequencer #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (req_valid),
    .use_ptr     (use_ptr),
    .direct_ea   (direct_ea),
    .ptr_lo_addr (ptr_lo_addr),
    .ptr_hi_addr (ptr_hi_addr),
    .post_add    (post_add),
    .idle        (idle),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_addr     (rd_addr),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .ea_valid    (ea_valid),
    .ea_ready    (ea_ready),
    .ea_addr     (ea_addr)
  );

  assign req_ready = idle;
endmodule

// File: rtl/addr_resolver_chk.sv
module addr_resolver_chk
  import addr_resolver_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [3:0]      req_mode,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [2*DW-1:0] rd_addr,
  input logic            ea_valid,
  input logic            ea_ready,
  input logic [2*DW-1:0] ea_addr
);
  logic [3:0] cur_mode;
  logic [1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= 4'd0;
      rd_cnt   <= '0;
    end else if (req_valid && req_ready) begin
      cur_mode <= req_mode;
      rd_cnt   <= '0;
    end else if (rd_valid && rd_ready && rd_cnt != 2'd3) begin
      rd_cnt <= rd_cnt + 2'd1;
    end
  end

  assert_idle_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_valid && !ea_valid);

  assert_ea_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid && !ea_ready |=> ea_valid && $stable(ea_addr));

  assert_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> is_ptr_mode(cur_mode));

  assert_zp_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid && is_zp_mode(cur_mode) |-> ea_addr[2*DW-1:DW] == '0);

  assert_zp_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && (cur_mode == AM_XIND || cur_mode == AM_INDY) |-> rd_addr[2*DW-1:DW] == '0);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_two_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid && is_ptr_mode(cur_mode) |-> rd_cnt == 2'd2);
endmodule

bind addr_resolver addr_resolver_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mode  (req_mode),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .ea_valid  (ea_valid),
  .ea_ready  (ea_ready),
  .ea_addr   (ea_addr)
);

// File: tb/test_addr_resolver.sv
`timescale 1ns/1ps
module test_addr_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_lo = '0, req_hi = '0, req_x = '0, req_y = '0;
  logic [15:0] req_pc = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [15:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic        ea_valid, ea_ready = 1'b0;
  logic [15:0] ea_addr;

  int tests = 0, fails = 0;
  int rd_cnt = 0;
  logic [15:0] rd_log [4];
  logic pend = 1'b0;
  logic [15:0] paddr = '0;
  int dly = 0;

  addr_resolver i_addr_resolver (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_lo(req_lo), .req_hi(req_hi), .req_x(req_x), .req_y(req_y), .req_pc(req_pc),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ea_valid(ea_valid), .ea_ready(ea_ready), .ea_addr(ea_addr)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    case (a)
      16'h4000: return 8'hD2;
      16'h4001: return 8'hFF;
      16'h0010: return 8'h00;
      16'h0011: return 8'h40;
      16'h0012: return 8'hC0;
      16'h0013: return 8'h40;
      16'h0014: return 8'hF8;
      16'h0015: return 8'h50;
      16'h0016: return 8'h40;
      16'h0017: return 8'hA0;
      default:  return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endcase
  endfunction

  function automatic logic is_ptr(input int m);
    return m == 8 || m == 9 || m == 10;
  endfunction

  function automatic logic [15:0] ptr_addr(input int m, input int which,
      input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] x);
    logic [7:0] t;
    if (m == 8) return {hi, lo} + 16'(which);
    t = (m == 9) ? 8'(lo + x) : lo;
    return {8'h00, 8'(t + 8'(which))};
  endfunction

  function automatic logic [15:0] exp_ea(input int m, input logic [7:0] lo,
      input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc);
    logic [15:0] p;
    case (m)
      0: return pc + 16'd1;
      1: return {8'h00, lo};
      2: return {8'h00, 8'(lo + x)};
      3: return {8'h00, 8'(lo + y)};
      4: return {hi, lo};
      5: return {hi, lo} + {8'h00, x};
      6: return {hi, lo} + {8'h00, y};
      7: return pc + 16'd2 + {{8{lo[7]}}, lo};
      8, 9, 10: begin
        p = {mb(ptr_addr(m, 1, lo, hi, x)), mb(ptr_addr(m, 0, lo, hi, x))};
        return (m == 10) ? p + {8'h00, y} : p;
      end
      default: return {hi, lo};
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R3";
      1, 2, 3: return "R4";
      4, 5, 6: return "R5";
      7: return "R6";
      8: return "R7";
      9: return "R8";
      10: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
      input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model: random acceptance, 1..3 cycle latency
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend) begin
        rd_ready = 1'b0;
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mb(paddr);
          pend      = 1'b0;
        end else dly--;
      end else begin
        rd_ready = ($urandom % 3) != 0;
        if (rd_ready && rd_valid && rst_n) begin
          paddr = rd_addr;
          pend  = 1'b1;
          dly   = $urandom % 3;
          if (rd_cnt < 4) rd_log[rd_cnt] = rd_addr;
          rd_cnt++;
        end
      end
    end
  end

  task automatic run_req(input int m, input logic [7:0] lo, input logic [7:0] hi,
      input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc, input int bp);
    logic [15:0] exp, got;
    int waited;
    string tg;
    tg = tag_of(m);
    exp = exp_ea(m, lo, hi, x, y, pc);
    @(negedge clk);
    rd_cnt = 0;
    req_mode = 4'(m); req_lo = lo; req_hi = hi; req_x = x; req_y = y; req_pc = pc;
    req_valid = 1'b1;
    waited = 0;
    while (!req_ready && waited < 100) begin @(negedge clk); waited++; end
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!ea_valid && waited < 100) begin @(negedge clk); waited++; end
    chk(ea_valid, "R1", "result never offered", 32'(ea_valid), 32'd1);
    got = ea_addr;
    chk(got == exp, tg, $sformatf("mode %0d address", m), 32'(got), 32'(exp));
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      if (!(ea_valid && ea_addr == got))
        chk(1'b0, "R2", "result dropped under back-pressure", 32'(ea_addr), 32'(got));
    end
    if (bp > 0) chk(ea_valid && ea_addr == got, "R2", "held after back-pressure", 32'(ea_addr), 32'(got));
    ea_ready = 1'b1;
    @(negedge clk);
    ea_ready = 1'b0;
    chk(!ea_valid && req_ready, "R2", "idle after transfer", {30'd0, ea_valid, req_ready}, 32'd1);
    if (is_ptr(m)) begin
      chk(rd_cnt == 2, "R10", "read count", 32'(rd_cnt), 32'd2);
      chk(rd_log[0] == ptr_addr(m, 0, lo, hi, x), tg, "low pointer address",
          32'(rd_log[0]), 32'(ptr_addr(m, 0, lo, hi, x)));
      chk(rd_log[1] == ptr_addr(m, 1, lo, hi, x), tg, "high pointer address",
          32'(rd_log[1]), 32'(ptr_addr(m, 1, lo, hi, x)));
    end else begin
      chk(rd_cnt == 0, (m == 0) ? "R3" : tg, "unexpected read", 32'(rd_cnt), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240716));
    repeat (4) @(negedge clk);
    chk(req_ready && !rd_valid && !ea_valid, "R1", "reset state",
        {29'd0, req_ready, rd_valid, ea_valid}, 32'h4);
    rst_n = 1'b1;
    // directed corners
    run_req(8,  8'h00, 8'h40, 8'h00, 8'h00, 16'h0200, 2);  // R7 $FFD2
    run_req(8,  8'hFF, 8'h40, 8'h00, 8'h00, 16'h0200, 0);  // R7 carry into page
    run_req(9,  8'h10, 8'h00, 8'h04, 8'h00, 16'h0200, 1);  // R8 $50F8
    run_req(9,  8'hFC, 8'h12, 8'h03, 8'h00, 16'h0200, 0);  // R8 high byte at $0000
    run_req(10, 8'h10, 8'h00, 8'h00, 8'h20, 16'h0200, 3);  // R9 $4020
    run_req(10, 8'hFF, 8'h33, 8'h00, 8'hF0, 16'h0200, 0);  // R9 wrap
    run_req(2,  8'hF0, 8'h77, 8'h20, 8'h00, 16'h0000, 0);  // R4 wrap to $0010
    run_req(3,  8'hFF, 8'h77, 8'h00, 8'h01, 16'h0000, 0);  // R4 wrap to $0000
    run_req(5,  8'hF0, 8'hFF, 8'h20, 8'h00, 16'h0000, 1);  // R5 wrap to $0010
    run_req(6,  8'hFF, 8'h12, 8'h00, 8'h01, 16'h0000, 0);  // R5 page crossing
    run_req(7,  8'h80, 8'h00, 8'h00, 8'h00, 16'h1000, 0);  // R6 -128
    run_req(7,  8'h7F, 8'h00, 8'h00, 8'h00, 16'h1000, 2);  // R6 +127
    run_req(0,  8'h55, 8'h66, 8'h00, 8'h00, 16'hFFFF, 0);  // R3 wrap
    run_req(13, 8'h34, 8'h12, 8'h05, 8'h06, 16'h0000, 1);  // R11 reserved
    // constrained random
    for (int n = 0; n < 400; n++) begin
      run_req(int'($urandom % 13), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 16'($urandom), int'($urandom % 4));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule